// File: doc/BRIEF.md
# Multi-lane DLL bring-up sequencer

This block drives the control registers of a group of delay-locked loops: one master lane plus up to four byte lanes. A start pulse captures a 32-bit phase word and the bus-width setting. The master lane goes through its three bring-up steps first. Then all selected byte lanes go through the same three steps together. Each step holds for a fixed number of microseconds, given as a count of clock cycles per microsecond.

The three steps are the same on every lane. Arm loads the phase, raises the disable line and holds the active-low reset low for 2 us. Open lowers both lines for 22 us. Release raises the reset line with disable still low, for 22 us. The lanes are plain register outputs. The analog loops they would control are outside this block. Busy is high for the whole sequence, and done stays high from the end of the sequence until the next start.

Top module: `dll_bringup_seq`

## Requirements
- R1: After reset, every lane drives phase 0, disable 0 and nreset 0, and busy and done are 0.
- R2: A start pulse while idle is taken at the next clock edge. From that edge, busy is 1, done is 0, and the master lane drives disable 1, nreset 0 and phase = phase word bits [21:16].
- R3: The master arm step lasts 2*U cycles (U = clock cycles per microsecond). Then disable 0 and nreset 0 are held for 22*U cycles. Then nreset is 1 with disable 0.
- R4: No byte lane output changes while the master lane runs. The byte lanes take their arm step exactly 46*U cycles after the start edge.
- R5: Byte lane k (k = 1..4) takes phase word bits [4k-1:4k-4], with lane 1 on bits [3:0]. The word is the one captured at the start edge, and later changes of the phase word input are ignored.
- R6: All selected byte lanes move together through arm (disable 1, nreset 0) for 2*U cycles, open (both 0) for 22*U cycles, then release (nreset 1, disable 0).
- R7: wide_bus_i = 1 at start selects byte lanes 1 to 4. wide_bus_i = 0 selects lanes 1 and 2 only. Unselected lanes keep their previous outputs.
- R8: Busy falls and done rises at the edge 92*U cycles after the start edge. Done then stays 1 until the next accepted start.
- R9: A start pulse while busy is ignored, and the running sequence keeps its timing.
- R10: No lane ever drives disable 1 and nreset 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| wide_bus_i | input | 1 | 1 = 32-bit bus (four byte lanes), 0 = 16-bit bus (two byte lanes) |
| phase_word_i | input | 32 | Phase word for all lanes |
| master_phase_o | output | 6 | Master lane phase |
| master_dis_o | output | 1 | Master lane disable |
| master_nrst_o | output | 1 | Master lane active-low reset |
| slave_phase_o | output | 16 | Byte lane phases, lane k at bits [4k-1:4k-4] |
| slave_dis_o | output | 4 | Byte lane disables, lane k at bit k-1 |
| slave_nrst_o | output | 4 | Byte lane active-low resets, lane k at bit k-1 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until the next start |

## Verification
The hardest case to reach is an unselected byte lane that still holds values, because only such a lane can show that a 16-bit run leaves it untouched. The bench first does a 32-bit run, which puts non-zero phases and a high nreset on all four byte lanes. It then does a 16-bit run and checks lanes 3 and 4 against that snapshot. During a run it also changes the phase word and pulses start again, to show that the captured word and the running timing do not change.

// File: rtl/dllseq_pkg.sv
// Shared types of the DLL bring-up sequencer.
// Assumes: used only by the dllseq_* modules and dll_bringup_seq.
package dllseq_pkg;
    // Command sent to a lane in the cycle before the edge that applies it
    typedef enum logic [1:0] {
        LCMD_HOLD    = 2'd0,
        LCMD_ARM     = 2'd1,
        LCMD_OPEN    = 2'd2,
        LCMD_RELEASE = 2'd3
    } lane_cmd_e;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_M_ARM  = 3'd1,
        SQ_M_OPEN = 3'd2,
        SQ_M_REL  = 3'd3,
        SQ_S_ARM  = 3'd4,
        SQ_S_OPEN = 3'd5,
        SQ_S_REL  = 3'd6
    } seq_state_e;
endpackage

// File: rtl/dllseq_timer.sv
// Step wait timer: loads a cycle count and counts down to zero.
// Assumes: a load of N-1 makes expired_o come back N cycles after the load edge.
module dllseq_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new wait, or count the current one down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (load_i)     cnt_q <= load_val_i;
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/dllseq_lane.sv
// One DLL lane register set: phase, disable and active-low reset.
// Assumes: commands are applied only when en_i is 1; otherwise the outputs hold.
module dllseq_lane
    import dllseq_pkg::*;
#(
    parameter int PH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  lane_cmd_e       cmd_i,
    input  logic [PH_W-1:0] phase_i,
    output logic [PH_W-1:0] phase_o,
    output logic            dis_o,
    output logic            nrst_o
);
    // Apply the step command to this lane's registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o <= '0;
            dis_o   <= 1'b0;
            nrst_o  <= 1'b0;
        end else if (en_i) begin
            case (cmd_i)
                LCMD_ARM: begin
                    phase_o <= phase_i;
                    dis_o   <= 1'b1;
                    nrst_o  <= 1'b0;
                end
                LCMD_OPEN: begin
                    dis_o  <= 1'b0;
                    nrst_o <= 1'b0;
                end
                LCMD_RELEASE: begin
                    dis_o  <= 1'b0;
                    nrst_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R10
    lane_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(dis_o && nrst_o));
endmodule

// File: rtl/dllseq_ctrl.sv
// Sequence controller: runs master arm/open/release, then the byte-lane steps.
// Assumes: the timer reports expiry one wait after each load it requests.
module dllseq_ctrl
    import dllseq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int WORD_W = 32,
    parameter int ARM_C  = 8,
    parameter int OPEN_C = 88,
    parameter int REL_C  = 88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              expired_i,
    output lane_cmd_e         m_cmd_o,
    output lane_cmd_e         s_cmd_o,
    output logic              tmr_load_o,
    output logic [CNT_W-1:0]  tmr_val_o,
    output logic [WORD_W-1:0] word_eff_o,
    output logic              wide_q_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam logic [CNT_W-1:0] ARM_V  = CNT_W'(ARM_C - 1);
    localparam logic [CNT_W-1:0] OPEN_V = CNT_W'(OPEN_C - 1);
    localparam logic [CNT_W-1:0] REL_V  = CNT_W'(REL_C - 1);

    seq_state_e        state_q, state_d;
    logic [WORD_W-1:0] word_q;

    // Next state, lane commands and timer loads for each step boundary
    always_comb begin
        state_d    = state_q;
        m_cmd_o    = LCMD_HOLD;
        s_cmd_o    = LCMD_HOLD;
        tmr_load_o = 1'b0;
        tmr_val_o  = '0;
        case (state_q)
            SQ_IDLE: if (start_i) begin
                state_d = SQ_M_ARM;  m_cmd_o = LCMD_ARM;
                tmr_load_o = 1'b1;   tmr_val_o = ARM_V;
            end
            SQ_M_ARM: if (expired_i) begin
                state_d = SQ_M_OPEN; m_cmd_o = LCMD_OPEN;
                tmr_load_o = 1'b1;   tmr_val_o = OPEN_V;
            end
            SQ_M_OPEN: if (expired_i) begin
                state_d = SQ_M_REL;  m_cmd_o = LCMD_RELEASE;
                tmr_load_o = 1'b1;   tmr_val_o = REL_V;
            end
            SQ_M_REL: if (expired_i) begin
                state_d = SQ_S_ARM;  s_cmd_o = LCMD_ARM;
                tmr_load_o = 1'b1;   tmr_val_o = ARM_V;
            end
            SQ_S_ARM: if (expired_i) begin
                state_d = SQ_S_OPEN; s_cmd_o = LCMD_OPEN;
                tmr_load_o = 1'b1;   tmr_val_o = OPEN_V;
            end
            SQ_S_OPEN: if (expired_i) begin
                state_d = SQ_S_REL;  s_cmd_o = LCMD_RELEASE;
                tmr_load_o = 1'b1;   tmr_val_o = REL_V;
            end
            SQ_S_REL: if (expired_i) state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    // State, captured word/width, and the sticky done flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SQ_IDLE;
            word_q   <= '0;
            wide_q_o <= 1'b0;
            done_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && start_i) begin
                word_q   <= word_i;
                wide_q_o <= wide_i;
                done_o   <= 1'b0;
            end
            if (state_q == SQ_S_REL && expired_i) done_o <= 1'b1;
        end
    end

    assign busy_o     = (state_q != SQ_IDLE);
    assign word_eff_o = (state_q == SQ_IDLE) ? word_i : word_q;

    // R8
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $fell(busy_o));
    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !expired_i) |=> (state_q == $past(state_q)));
endmodule

// File: rtl/dll_bringup_seq.sv
// Top of the DLL bring-up sequencer: one master lane and MAX_SLAVES byte lanes.
// Assumes: start_i is a pulse; the bus width is sampled with the start pulse.
module dll_bringup_seq
    import dllseq_pkg::*;
#(
    parameter int CLK_PER_US    = 100,
    parameter int ARM_US        = 2,
    parameter int OPEN_US       = 22,
    parameter int REL_US        = 22,
    parameter int MAX_SLAVES    = 4,
    parameter int NARROW_SLAVES = 2,
    parameter int WORD_W        = 32,
    parameter int M_PH_W        = 6,
    parameter int M_PH_LSB      = 16,
    parameter int S_PH_W        = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start_i,
    input  logic                         wide_bus_i,
    input  logic [WORD_W-1:0]            phase_word_i,
    output logic [M_PH_W-1:0]            master_phase_o,
    output logic                         master_dis_o,
    output logic                         master_nrst_o,
    output logic [MAX_SLAVES*S_PH_W-1:0] slave_phase_o,
    output logic [MAX_SLAVES-1:0]        slave_dis_o,
    output logic [MAX_SLAVES-1:0]        slave_nrst_o,
    output logic                         busy_o,
    output logic                         done_o
);
    localparam int ARM_C  = ARM_US * CLK_PER_US;
    localparam int OPEN_C = OPEN_US * CLK_PER_US;
    localparam int REL_C  = REL_US * CLK_PER_US;
    localparam int MAX_C  = (OPEN_C > REL_C) ? ((OPEN_C > ARM_C) ? OPEN_C : ARM_C)
                                             : ((REL_C > ARM_C) ? REL_C : ARM_C);
    localparam int CNT_W  = $clog2(MAX_C + 1);

    lane_cmd_e         m_cmd, s_cmd;
    logic              tmr_load, tmr_exp, wide_q;
    logic [CNT_W-1:0]  tmr_val;
    logic [WORD_W-1:0] word_eff;

    dllseq_ctrl #(
        .CNT_W(CNT_W), .WORD_W(WORD_W),
        .ARM_C(ARM_C), .OPEN_C(OPEN_C), .REL_C(REL_C)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_bus_i),
        .word_i(phase_word_i), .expired_i(tmr_exp),
        .m_cmd_o(m_cmd), .s_cmd_o(s_cmd), .tmr_load_o(tmr_load),
        .tmr_val_o(tmr_val), .word_eff_o(word_eff), .wide_q_o(wide_q),
        .busy_o(busy_o), .done_o(done_o)
    );

    dllseq_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .expired_o(tmr_exp)
    );

    dllseq_lane #(.PH_W(M_PH_W)) master_i (
        .clk(clk), .rst_n(rst_n), .en_i(1'b1), .cmd_i(m_cmd),
        .phase_i(word_eff[M_PH_LSB +: M_PH_W]),
        .phase_o(master_phase_o), .dis_o(master_dis_o), .nrst_o(master_nrst_o)
    );

    for (genvar k = 0; k < MAX_SLAVES; k++) begin : g_slave
        localparam bit IN_NARROW = (k < NARROW_SLAVES);
        logic lane_en;
        // A byte lane is selected by the captured bus width
        assign lane_en = wide_q || IN_NARROW;
        dllseq_lane #(.PH_W(S_PH_W)) slave_i (
            .clk(clk), .rst_n(rst_n), .en_i(lane_en), .cmd_i(s_cmd),
            .phase_i(word_eff[k*S_PH_W +: S_PH_W]),
            .phase_o(slave_phase_o[k*S_PH_W +: S_PH_W]),
            .dis_o(slave_dis_o[k]), .nrst_o(slave_nrst_o[k])
        );
    end

    // R4
    slave_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !master_nrst_o)
            |-> ($stable(slave_dis_o) && $stable(slave_nrst_o) && $stable(slave_phase_o)));
endmodule

// File: tb/dll_bringup_seq_tb.sv
// Directed bench for dll_bringup_seq: one task per scenario.
module dll_bringup_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int U  = 4;
    localparam int T1 = 2 * U;
    localparam int T2 = 22 * U;
    localparam int T3 = 22 * U;
    localparam int M  = T1 + T2 + T3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        wide = 1'b0;
    logic [31:0] word = '0;
    logic [5:0]  m_ph;
    logic        m_dis, m_nrst, busy, done;
    logic [15:0] s_ph;
    logic [3:0]  s_dis, s_nrst;

    int checks = 0;
    int failures = 0;
    int cur = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dll_bringup_seq #(.CLK_PER_US(U)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .wide_bus_i(wide),
        .phase_word_i(word), .master_phase_o(m_ph), .master_dis_o(m_dis),
        .master_nrst_o(m_nrst), .slave_phase_o(s_ph), .slave_dis_o(s_dis),
        .slave_nrst_o(s_nrst), .busy_o(busy), .done_o(done)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Advance to the negedge following edge E0+k
    task automatic go_to(input int k);
        repeat (k - cur) @(posedge clk);
        @(negedge clk);
        cur = k;
    endtask

    task automatic test_reset();
        check("R1 master", {24'd0, m_ph, m_dis, m_nrst}, 32'd0);
        check("R1 slaves", {8'd0, s_ph, s_dis, s_nrst}, 32'd0);
        check("R1 busy/done", {30'd0, busy, done}, 32'd0);
    endtask

    // One full run; poke changes the word and re-pulses start mid-run
    task automatic test_run(input logic w, input logic [31:0] pw, input bit poke);
        logic [15:0] old_ph, exp_ph;
        logic [3:0]  old_d, old_n, sel;
        old_ph = s_ph; old_d = s_dis; old_n = s_nrst;
        sel    = w ? 4'hF : 4'h3;
        exp_ph = w ? pw[15:0] : {old_ph[15:8], pw[7:0]};
        word = pw; wide = w; start = 1'b1;
        @(posedge clk); cur = 0; @(negedge clk);
        start = 1'b0;
        check("R2 busy/done", {30'd0, busy, done}, 32'd2);
        check("R2 master arm", {24'd0, m_ph, m_dis, m_nrst}, {24'd0, pw[21:16], 2'b10});
        if (poke) begin
            word = ~pw; wide = ~w; start = 1'b1;
            go_to(3);
            start = 1'b0;
        end
        go_to(T1 - 1);
        check("R3 arm held", {30'd0, m_dis, m_nrst}, 32'd2);
        go_to(T1);
        check("R3 open", {30'd0, m_dis, m_nrst}, 32'd0);
        go_to(T1 + T2 - 1);
        check("R3 open held", {30'd0, m_dis, m_nrst}, 32'd0);
        go_to(T1 + T2);
        check("R3 release", {30'd0, m_dis, m_nrst}, 32'd1);
        go_to(M - 1);
        check("R4 slaves quiet", {8'd0, s_ph, s_dis, s_nrst}, {8'd0, old_ph, old_d, old_n});
        go_to(M);
        check("R5 slave phases", {16'd0, s_ph}, {16'd0, exp_ph});
        check("R6 slave arm", {24'd0, s_dis, s_nrst},
              {24'd0, (sel | old_d), (old_n & ~sel)});
        go_to(M + T1);
        check("R6 slave open", {24'd0, s_dis, s_nrst},
              {24'd0, (old_d & ~sel), (old_n & ~sel)});
        go_to(M + T1 + T2);
        check("R6 slave release", {24'd0, s_dis, s_nrst},
              {24'd0, (old_d & ~sel), (old_n | sel)});
        if (!w) check("R7 unused lanes kept", {16'd0, s_ph[15:8], s_dis[3:2], s_nrst[3:2], 4'd0},
                      {16'd0, old_ph[15:8], old_d[3:2], old_n[3:2], 4'd0});
        go_to(2*M - 1);
        check("R8/R9 still busy", {30'd0, busy, done}, 32'd2);
        go_to(2*M);
        check("R8 done", {30'd0, busy, done}, 32'd1);
        go_to(2*M + 20);
        check("R8 done held", {30'd0, busy, done}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_run(1'b1, 32'h002A_9C5B, 1'b1); // R7 wide, R9 poke, R5 capture
        test_run(1'b0, 32'h0015_0076, 1'b0); // R7 narrow
        test_run(1'b1, 32'h003F_FFFF, 1'b0); // all-ones fields
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 50000);
        failures++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule